// File: doc/BRIEF.md
# Clock-Calendar Counter Chain

This block keeps time of day and calendar date as a cascade of binary counters. A prescaler divides an input tick down to one hundredth of a second. Each hundredth advances the sub-second counter, and its wrap carries into seconds. The carry then ripples through minutes, hours, day of month, month and year. Three side counters advance with the main chain: a four-year leap position, a day-of-year count and a day-of-week count.

Software reads and writes every counter through a byte-wide register port. Reads are combinational. A write loads the addressed counter directly and restarts the prescaler, so the next hundredth comes one full prescale period after the write. Hours run either on a 24-hour dial or on a 12-hour dial with an AM/PM flag. All values are plain binary.

Top module: `cal_chain`

## Requirements
- R1: After reset, the counters read as follows. Hundredths, seconds, minutes, hours, year and leap position read 0. Day of month, month, day of year and day of week read 1. The mode register reads 0, which selects 24-hour mode and AM.
- R2: The hundredths counter advances once for every PRESCALE cycles with `tick_i` high. Any register write clears the prescaler, so the first advance after a write comes on the PRESCALE-th tick after it.
- R3: Hundredths count 0–99, and seconds and minutes each count 0–59. When a counter passes its top value it returns to 0 and advances the next counter up.
- R4: In 24-hour mode (mode bit 0 = 0), hours count 0–23. The step from 23 to 0 advances the day.
- R5: In 12-hour mode (mode bit 0 = 1), hours count 1–12, and 12 is followed by 1. The step from 11 to 12 inverts the PM flag (mode bit 1). The day advances only on the 11 to 12 step that starts with PM set.
- R6: The last day of the month depends on the month. Months 4, 6, 9 and 11 end on day 30. Month 2 ends on day 29 when the leap position is 0 and on day 28 otherwise. All other months end on day 31. After the last day the day returns to 1 and the month advances.
- R7: Months count 1–12. The step from 12 to 1 advances the year (0–99, 99 wraps to 0) and the leap position (0–3, 3 wraps to 0).
- R8: The day-of-year count is 9 bits wide. Bits 7:0 are at address 8, and bit 8 is bit 0 of address 9. It increments on every new day and returns to 1 when the month goes from 12 to 1.
- R9: The day of week counts 1–7 and advances on every new day, with 7 followed by 1.
- R10: With `wr_en_i` high, the counter at `addr_i` loads `wdata_i` on the clock edge, and this takes priority over an advance in the same cycle. A loaded value at or above the counter's top value goes to the counter's lowest value on the next advance and carries.
- R11: `rdata_o` shows the register at `addr_i` combinationally. The map is: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 month, 6 year, 7 leap position, 8/9 day of year, 10 day of week, 11 mode. Addresses 12–15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaler input tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |

## Verification
The bench starts on 1 January of a year whose leap position is 3 and forces a midnight rollover for each of 1461 consecutive days. After each one it compares day, month, year, leap position, day of year and day of week against an arithmetic calendar. This catches a wrong month length or a February that ignores the leap position. It also catches a day-of-year count that misses its reset to 1 or runs past 365/366, and a leap or year wrap placed at the wrong month. Two sweeps cover every hour step in both dials. They catch a 12-hour dial whose day change happens at noon rather than midnight, and a PM flag that flips on the wrong step. Directed cases then cover the rest. A write that lands in the same cycle as a pending step must not gain or lose a hundredth. A prescaler that is not cleared on a write would shift the next advance early. An out-of-range seconds value must still wrap and carry.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [3:0] {
    RA_CS    = 4'd0,
    RA_SEC   = 4'd1,
    RA_MIN   = 4'd2,
    RA_HOUR  = 4'd3,
    RA_DAY   = 4'd4,
    RA_MON   = 4'd5,
    RA_YEAR  = 4'd6,
    RA_LEAP  = 4'd7,
    RA_DOYLO = 4'd8,
    RA_DOYHI = 4'd9,
    RA_DOW   = 4'd10,
    RA_MODE  = 4'd11
  } cal_addr_e;

  // Last day of a month; leap0 is true in the leap year of the cycle.
  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap0);
    logic [7:0] last;
    unique case (mon)
      8'd2:                      last = leap0 ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   last = 8'd30;
      default:                   last = 8'd31;
    endcase
    return last;
  endfunction

endpackage

// File: rtl/cal_prescale.sv
module cal_prescale #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clr_i,
  output logic step_o
);
  localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          cnt_en;

  always_comb begin
    step_o  = tick_i && !clr_i && (cnt_q == LAST);
    cnt_en  = clr_i || tick_i;
    cnt_nxt = cnt_q;
    if (clr_i)       cnt_nxt = '0;
    else if (step_o) cnt_nxt = '0;
    else if (tick_i) cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  // R2
  clr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !step_o);

endmodule

// File: rtl/cal_digit.sv
module cal_digit #(
  parameter int          W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] q_o,
  output logic         top_o
);
  logic [W-1:0] q_q, q_nxt;
  logic         q_en;

  always_comb begin
    top_o = (q_q >= hi_i);
    q_en  = ld_i || inc_i;
    q_nxt = q_q;
    if (ld_i)       q_nxt = ld_val_i;
    else if (inc_i) q_nxt = top_o ? lo_i : q_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= RST;
    else if (q_en) q_q <= q_nxt;
  end

  assign q_o = q_q;

  // R10
  ld_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> q_o == $past(ld_val_i));

  // R3
  wrap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i && q_o >= hi_i) |=> q_o == $past(lo_i));

endmodule

// File: rtl/cal_hour.sv
module cal_hour (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc_i,
  input  logic       ld_hour_i,
  input  logic       ld_mode_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] hour_o,
  output logic       h12_o,
  output logic       pm_o,
  output logic       day_inc_o
);
  logic [7:0] hour_q, hour_nxt;
  logic       h12_q, h12_nxt, pm_q, pm_nxt;
  logic       hour_en, mode_en, to_noon;

  always_comb begin
    to_noon   = h12_q && (hour_q == 8'd11);
    day_inc_o = inc_i && (h12_q ? (to_noon && pm_q) : (hour_q >= 8'd23));
    hour_en   = ld_hour_i || inc_i;
    mode_en   = ld_mode_i || (inc_i && to_noon);
    hour_nxt  = hour_q;
    if (ld_hour_i)  hour_nxt = wdata_i;
    else if (inc_i) begin
      if (h12_q) hour_nxt = (hour_q >= 8'd12) ? 8'd1 : hour_q + 8'd1;
      else       hour_nxt = (hour_q >= 8'd23) ? 8'd0 : hour_q + 8'd1;
    end
    h12_nxt = ld_mode_i ? wdata_i[0] : h12_q;
    pm_nxt  = ld_mode_i ? wdata_i[1] : ~pm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hour_q <= '0;
    else if (hour_en) hour_q <= hour_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h12_q <= 1'b0;
      pm_q  <= 1'b0;
    end else if (mode_en) begin
      h12_q <= h12_nxt;
      pm_q  <= pm_nxt;
    end
  end

  assign hour_o = hour_q;
  assign h12_o  = h12_q;
  assign pm_o   = pm_q;

  // R5
  pm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_mode_i && !ld_hour_i && h12_o && hour_o == 8'd11) |=> (pm_o != $past(pm_o) && hour_o == 8'd12));

  // R4
  hour24_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_mode_i && !ld_hour_i && !h12_o && hour_o == 8'd23) |=> hour_o == 8'd0);

endmodule

// File: rtl/cal_chain.sv
module cal_chain #(
  parameter int PRESCALE = 4,
  parameter int AW       = 4,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  import cal_pkg::*;

  localparam int NBASE = 3;  // hundredths, seconds, minutes

  logic [1:0] rsync_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int = rsync_q[1];

  logic step;
  cal_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_int), .tick_i(tick_i), .clr_i(wr_en_i), .step_o(step)
  );

  logic [DW-1:0] base_q [NBASE];
  logic [NBASE-1:0] base_top, base_inc;
  logic             hour_inc;

  always_comb begin
    logic acc;
    acc = step;
    for (int i = 0; i < NBASE; i++) begin
      base_inc[i] = acc;
      acc = acc && base_top[i];
    end
    hour_inc = acc;
  end

  for (genvar g = 0; g < NBASE; g++) begin : g_base
    localparam logic [DW-1:0] HI = (g == 0) ? DW'(99) : DW'(59);
    cal_digit #(.W(DW), .RST('0)) u_cnt (
      .clk(clk), .rst_n(rst_int), .lo_i('0), .hi_i(HI), .inc_i(base_inc[g]),
      .ld_i(wr_en_i && addr_i == AW'(g)), .ld_val_i(wdata_i),
      .q_o(base_q[g]), .top_o(base_top[g])
    );
  end

  logic [DW-1:0] hour_q;
  logic          h12, pm, day_inc;
  cal_hour u_hour (
    .clk(clk), .rst_n(rst_int), .inc_i(hour_inc),
    .ld_hour_i(wr_en_i && addr_i == AW'(RA_HOUR)),
    .ld_mode_i(wr_en_i && addr_i == AW'(RA_MODE)),
    .wdata_i(wdata_i), .hour_o(hour_q), .h12_o(h12), .pm_o(pm), .day_inc_o(day_inc)
  );

  logic [DW-1:0] day_q, mon_q, year_q, leap_q, dow_q, day_last;
  logic          day_top, mon_top, year_top, leap_top, dow_top;
  logic          mon_inc, year_inc;

  assign day_last = month_last(mon_q, leap_q == '0);
  assign mon_inc  = day_inc && day_top;
  assign year_inc = mon_inc && mon_top;

  cal_digit #(.W(DW), .RST(DW'(1))) u_day (
    .clk(clk), .rst_n(rst_int), .lo_i(DW'(1)), .hi_i(day_last), .inc_i(day_inc),
    .ld_i(wr_en_i && addr_i == AW'(RA_DAY)), .ld_val_i(wdata_i), .q_o(day_q), .top_o(day_top)
  );
  cal_digit #(.W(DW), .RST(DW'(1))) u_mon (
    .clk(clk), .rst_n(rst_int), .lo_i(DW'(1)), .hi_i(DW'(12)), .inc_i(mon_inc),
    .ld_i(wr_en_i && addr_i == AW'(RA_MON)), .ld_val_i(wdata_i), .q_o(mon_q), .top_o(mon_top)
  );
  cal_digit #(.W(DW), .RST('0)) u_year (
    .clk(clk), .rst_n(rst_int), .lo_i('0), .hi_i(DW'(99)), .inc_i(year_inc),
    .ld_i(wr_en_i && addr_i == AW'(RA_YEAR)), .ld_val_i(wdata_i), .q_o(year_q), .top_o(year_top)
  );
  cal_digit #(.W(DW), .RST('0)) u_leap (
    .clk(clk), .rst_n(rst_int), .lo_i('0), .hi_i(DW'(3)), .inc_i(year_inc),
    .ld_i(wr_en_i && addr_i == AW'(RA_LEAP)), .ld_val_i(wdata_i), .q_o(leap_q), .top_o(leap_top)
  );
  cal_digit #(.W(DW), .RST(DW'(1))) u_dow (
    .clk(clk), .rst_n(rst_int), .lo_i(DW'(1)), .hi_i(DW'(7)), .inc_i(day_inc),
    .ld_i(wr_en_i && addr_i == AW'(RA_DOW)), .ld_val_i(wdata_i), .q_o(dow_q), .top_o(dow_top)
  );

  logic [8:0] doy_q, doy_nxt;
  logic       doy_ld_lo, doy_ld_hi, doy_en;

  always_comb begin
    doy_ld_lo = wr_en_i && addr_i == AW'(RA_DOYLO);
    doy_ld_hi = wr_en_i && addr_i == AW'(RA_DOYHI);
    doy_en    = doy_ld_lo || doy_ld_hi || day_inc;
    doy_nxt   = doy_q;
    if (doy_ld_lo || doy_ld_hi) begin
      if (doy_ld_lo) doy_nxt[7:0] = wdata_i[7:0];
      if (doy_ld_hi) doy_nxt[8]   = wdata_i[0];
    end else if (day_inc) begin
      doy_nxt = year_inc ? 9'd1 : doy_q + 9'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)    doy_q <= 9'd1;
    else if (doy_en) doy_q <= doy_nxt;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(RA_CS):    rdata_o = base_q[0];
      AW'(RA_SEC):   rdata_o = base_q[1];
      AW'(RA_MIN):   rdata_o = base_q[2];
      AW'(RA_HOUR):  rdata_o = hour_q;
      AW'(RA_DAY):   rdata_o = day_q;
      AW'(RA_MON):   rdata_o = mon_q;
      AW'(RA_YEAR):  rdata_o = year_q;
      AW'(RA_LEAP):  rdata_o = leap_q;
      AW'(RA_DOYLO): rdata_o = doy_q[7:0];
      AW'(RA_DOYHI): rdata_o = DW'(doy_q[8]);
      AW'(RA_DOW):   rdata_o = dow_q;
      AW'(RA_MODE):  rdata_o = DW'({pm, h12});
      default:       rdata_o = '0;
    endcase
  end

  // R8
  doy_newyear_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (year_inc && !wr_en_i) |=> doy_q == 9'd1);

  // R6
  day_limit_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (day_inc && !wr_en_i && day_q == day_last) |=> (day_q == DW'(1) && mon_q != $past(mon_q)));

endmodule

// File: tb/test_cal_chain.sv
module test_cal_chain;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cal_chain #(.PRESCALE(P)) i_cal_chain (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  task automatic check(input string req, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 4'(a); wdata_i = 8'(d);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wr_tick(input int a, input int d);
    @(negedge clk);
    wr_en_i = 1'b1; tick_i = 1'b1; addr_i = 4'(a); wdata_i = 8'(d);
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr_i = 4'(a);
    #1 v = int'(rdata_o);
  endtask

  function automatic int mlen(input int m, input int lp);
    if (m == 2) return (lp == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int v, lo, hi;
    int d, m, y, lp, doy, dow, h, pm, dexp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(0, v);  check("R1 hundredths", v, 0);
    rd(1, v);  check("R1 seconds", v, 0);
    rd(2, v);  check("R1 minutes", v, 0);
    rd(3, v);  check("R1 hours", v, 0);
    rd(4, v);  check("R1 day", v, 1);
    rd(5, v);  check("R1 month", v, 1);
    rd(6, v);  check("R1 year", v, 0);
    rd(7, v);  check("R1 leap", v, 0);
    rd(8, v);  check("R1 doy low", v, 1);
    rd(9, v);  check("R1 doy high", v, 0);
    rd(10, v); check("R1 dow", v, 1);
    rd(11, v); check("R1 mode", v, 0);
    rd(12, v); check("R11 unused addr", v, 0);

    // R2 prescaler and write restart
    wr(0, 10);
    ticks(P - 1); rd(0, v); check("R2 before period", v, 10);
    ticks(1);     rd(0, v); check("R2 at period", v, 11);
    ticks(2 * P); rd(0, v); check("R2 two periods", v, 13);
    wr(0, 0); ticks(P - 1);
    wr_tick(0, 50); rd(0, v); check("R10 write beats step", v, 50);
    ticks(P - 1); rd(0, v); check("R2 no early step after write", v, 50);
    ticks(1);     rd(0, v); check("R2 step after write", v, 51);

    // R3 full hundredths sweep into seconds
    wr(1, 0); wr(0, 0);
    ticks(100 * P);
    rd(0, v); check("R3 hundredths wrap", v, 0);
    rd(1, v); check("R3 seconds carry", v, 1);
    wr(2, 5); wr(1, 59); wr(0, 99); ticks(P);
    rd(1, v); check("R3 seconds wrap", v, 0);
    rd(2, v); check("R3 minutes carry", v, 6);
    wr(2, 59); wr(1, 59); wr(0, 99); ticks(P);
    rd(2, v); check("R3 minutes wrap", v, 0);

    // R10 out-of-range load wraps and carries
    wr(2, 5); wr(1, 75); wr(0, 99); ticks(P);
    rd(1, v); check("R10 oversize seconds wrap", v, 0);
    rd(2, v); check("R10 oversize carry", v, 6);

    // R4 24-hour sweep
    wr(5, 1);
    for (int hh = 0; hh < 24; hh++) begin
      wr(4, 10); wr(3, hh); wr(2, 59); wr(1, 59); wr(0, 99); ticks(P);
      rd(3, v); check("R4 hour step", v, (hh + 1) % 24);
      rd(4, v); check("R4 day advance", v, (hh == 23) ? 11 : 10);
    end

    // R5 12-hour sweep over two days
    wr(11, 1); wr(3, 1); wr(4, 10);
    h = 1; pm = 0; dexp = 10;
    for (int k = 0; k < 48; k++) begin
      wr(2, 59); wr(1, 59); wr(0, 99); ticks(P);
      if (h == 11) begin
        if (pm == 1) dexp++;
        pm = 1 - pm;
      end
      h = (h == 12) ? 1 : h + 1;
      rd(3, v);  check("R5 hour step", v, h);
      rd(11, v); check("R5 pm flag", (v >> 1) & 1, pm);
      rd(4, v);  check("R5 day only at midnight", v, dexp);
    end

    // R6 R7 R8 R9 four-year day sweep in 24-hour mode
    wr(11, 0);
    wr(6, 99); wr(7, 3); wr(5, 1); wr(4, 1); wr(8, 1); wr(9, 0); wr(10, 1);
    d = 1; m = 1; y = 99; lp = 3; doy = 1; dow = 1;
    for (int k = 0; k < 1461; k++) begin
      wr(3, 23); wr(2, 59); wr(1, 59); wr(0, 99); ticks(P);
      dow = (dow == 7) ? 1 : dow + 1;
      if (d == mlen(m, lp)) begin
        d = 1;
        if (m == 12) begin
          m = 1; y = (y == 99) ? 0 : y + 1; lp = (lp + 1) % 4; doy = 1;
        end else begin
          m++; doy++;
        end
      end else begin
        d++; doy++;
      end
      rd(4, v);  check("R6 day of month", v, d);
      rd(5, v);  check("R7 month", v, m);
      rd(6, v);  check("R7 year", v, y);
      rd(7, v);  check("R7 leap position", v, lp);
      rd(8, lo); rd(9, hi);
      check("R8 day of year", lo + 256 * (hi & 1), doy);
      rd(10, v); check("R9 day of week", v, dow);
    end

    // R11 write to unused address is ignored
    wr(1, 33);
    wr(13, 255);
    rd(13, v); check("R11 unused readback", v, 0);
    rd(1, v);  check("R11 seconds untouched", v, 33);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule